// File: doc/BRIEF.md
# Settable BCD Modulo-60 Counter

This block is one digit pair of a digital clock: it counts a one-per-second (or one-per-minute) strobe modulo 60, holds the value as a high and a low BCD digit, and emits a one-cycle carry whenever the count passes from the top value back to zero, so the next stage can count it. A second register alongside the live count stores an alarm target for the same digit pair.

A single setting key serves both registers. A target-select input steers each key strobe either into the live count, where it acts as one extra tick, or into the alarm register, which then steps by one and wraps without any carry while timekeeping runs on undisturbed. Two decoded flags mark the positions at which a downstream tone generator sounds the low beeps and the final high beep of an hourly chime.

All strobes (tick, key, clear) are single-cycle pulses synchronous to the system clock. A tick and a time-mode key strobe in the same cycle advance the count by two.

Top module: `bcd_mod_counter`

## Requirements
- R1: While `rst` is high, at the next rising edge the live count, the alarm register and `carry` all become zero (digits 0, 0).
- R2: A `tick` strobe with `en` high advances the live count by one, modulo `MODULUS` (60); the value is held as `cnt_hi` (tens, 0 to 5) and `cnt_lo` (units, 0 to 9).
- R3: A `tick` strobe with `en` low leaves the live count unchanged.
- R4: `carry` is high for exactly the one cycle after a rising edge at which the live count passed from 59 back through 00; it is low in every other cycle.
- R5: With `sel_alarm` = 0, a `key` strobe advances the live count by one whatever `en` is; a key strobe and an enabled tick in the same cycle advance it by two (58 goes to 00 and 59 goes to 01, each with a carry).
- R6: With `sel_alarm` = 1, a `key` strobe advances the alarm register (`alm_hi`, `alm_lo`) by one modulo 60 with no carry, and the live count behaves as if no key strobe had arrived; the alarm register changes on nothing else but reset.
- R7: `clr` high at a rising edge zeroes the live count and drops `carry`, overriding any tick or key advance, and leaves the alarm register unchanged.
- R8: `beep_lo` is high exactly while the live count is 50, 52, 54, 56 or 58.
- R9: `beep_hi` is high exactly while the live count is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset of all state |
| tick | input | 1 | Counting strobe, one cycle wide |
| en | input | 1 | Allows `tick` to count |
| clr | input | 1 | Synchronous clear of the live count |
| key | input | 1 | Setting strobe, one cycle wide |
| sel_alarm | input | 1 | Key target: 1 alarm register, 0 live count |
| cnt_hi | output | 4 | Live count tens digit (BCD) |
| cnt_lo | output | 4 | Live count units digit (BCD) |
| alm_hi | output | 4 | Alarm tens digit (BCD) |
| alm_lo | output | 4 | Alarm units digit (BCD) |
| carry | output | 1 | One-cycle pulse after the count wraps |
| beep_lo | output | 1 | Low-beep chime position flag |
| beep_hi | output | 1 | High-beep chime position flag |

## Verification
The bench builds the block with its default parameters, modulus 60 with the low-beep run starting at 50 for five beeps, because that small state space of 60 live values times 60 alarm values can be walked many times over in a few thousand cycles. Directed phases sweep the live count through several full wraps, the alarm register through a full lap and beyond, and the key in time mode with counting disabled; a long pseudo-random phase then mixes ticks, enable, key, target and rare clears so that the double advance from 58 and from 59, clears landing on a wrap and alarm strobes racing ticks all occur. Every cycle the digits, carry, alarm and chime flags are compared against an arithmetic model kept as plain integers.

// File: rtl/bcdcnt_pkg.sv
package bcdcnt_pkg;

    typedef struct packed {
        logic [3:0] hi;
        logic [3:0] lo;
    } bcd2_t;

    localparam bcd2_t BCD_ZERO = '0;

    // Step a two-digit BCD value by one; the value after `last` is zero.
    function automatic bcd2_t bcd_inc(bcd2_t v, bcd2_t last);
        bcd2_t r;
        if (v == last) begin
            r = BCD_ZERO;
        end else if (v.lo == 4'd9) begin
            r.hi = v.hi + 4'd1;
            r.lo = 4'd0;
        end else begin
            r.hi = v.hi;
            r.lo = v.lo + 4'd1;
        end
        return r;
    endfunction

    function automatic bcd2_t to_bcd(int unsigned n);
        bcd2_t r;
        r.hi = 4'(n / 10);
        r.lo = 4'(n % 10);
        return r;
    endfunction

    function automatic logic [6:0] to_bin(bcd2_t v);
        return 7'(v.hi) * 7'd10 + 7'(v.lo);
    endfunction

endpackage

// File: rtl/bcd_step.sv
module bcd_step
    import bcdcnt_pkg::*;
#(
    parameter bcd2_t LAST = 8'h59
) (
    input  bcd2_t      cur,
    input  logic [1:0] amt,
    output bcd2_t      nxt,
    output logic       wrapped
);
    bcd2_t plus1;
    bcd2_t plus2;

    always_comb begin
        plus1 = bcd_inc(cur, LAST);
        plus2 = bcd_inc(plus1, LAST);
        unique case (amt)
            2'd0: begin
                nxt     = cur;
                wrapped = 1'b0;
            end
            2'd1: begin
                nxt     = plus1;
                wrapped = (cur == LAST);
            end
            default: begin
                nxt     = plus2;
                wrapped = (cur == LAST) || (plus1 == LAST);
            end
        endcase
    end
endmodule

// File: rtl/chime_decode.sv
module chime_decode
    import bcdcnt_pkg::*;
#(
    parameter int unsigned FIRST = 50,
    parameter int unsigned BEEPS = 5
) (
    input  bcd2_t val,
    output logic  lo_beep,
    output logic  hi_beep
);
    localparam logic [6:0] START = 7'(FIRST);
    localparam logic [6:0] STOP  = 7'(FIRST + 2 * BEEPS);

    logic [6:0] bin;
    logic [6:0] offs;

    always_comb begin
        bin     = to_bin(val);
        offs    = bin - START;
        lo_beep = (bin >= START) && (bin < STOP) && !offs[0];
        hi_beep = (bin == 7'd0);
    end
endmodule

// File: rtl/bcd_mod_counter.sv
module bcd_mod_counter
    import bcdcnt_pkg::*;
#(
    parameter int unsigned MODULUS     = 60,
    parameter int unsigned CHIME_FIRST = 50,
    parameter int unsigned CHIME_BEEPS = 5
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       en,
    input  logic       clr,
    input  logic       key,
    input  logic       sel_alarm,
    output logic [3:0] cnt_hi,
    output logic [3:0] cnt_lo,
    output logic [3:0] alm_hi,
    output logic [3:0] alm_lo,
    output logic       carry,
    output logic       beep_lo,
    output logic       beep_hi
);
    localparam bcd2_t LAST = to_bcd(MODULUS - 1);

    bcd2_t      live_q;
    bcd2_t      live_nxt;
    bcd2_t      alarm_q;
    logic       wrap;
    logic       carry_q;
    logic [1:0] amt;

    // Enabled tick and time-mode key each contribute one step.
    assign amt = {1'b0, tick & en} + {1'b0, key & ~sel_alarm};

    bcd_step #(.LAST(LAST)) u_step (
        .cur     (live_q),
        .amt     (amt),
        .nxt     (live_nxt),
        .wrapped (wrap)
    );

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            live_q  <= BCD_ZERO;
            carry_q <= 1'b0;
        end else begin
            live_q  <= live_nxt;
            carry_q <= wrap;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            alarm_q <= BCD_ZERO;
        end else if (key && sel_alarm) begin
            alarm_q <= bcd_inc(alarm_q, LAST);
        end
    end

    chime_decode #(.FIRST(CHIME_FIRST), .BEEPS(CHIME_BEEPS)) u_chime (
        .val     (live_q),
        .lo_beep (beep_lo),
        .hi_beep (beep_hi)
    );

    assign cnt_hi = live_q.hi;
    assign cnt_lo = live_q.lo;
    assign alm_hi = alarm_q.hi;
    assign alm_lo = alarm_q.lo;
    assign carry  = carry_q;
endmodule

// File: rtl/bcd_mod_counter_chk.sv
module bcd_mod_counter_chk #(
    parameter int unsigned MODULUS = 60
) (
    input logic       clk,
    input logic       rst,
    input logic       tick,
    input logic       en,
    input logic       clr,
    input logic       key,
    input logic       sel_alarm,
    input logic [3:0] cnt_hi,
    input logic [3:0] cnt_lo,
    input logic [3:0] alm_hi,
    input logic [3:0] alm_lo,
    input logic       carry,
    input logic       beep_lo,
    input logic       beep_hi
);
    logic [6:0] live_bin;
    logic [6:0] alm_bin;
    assign live_bin = 7'(cnt_hi) * 7'd10 + 7'(cnt_lo);
    assign alm_bin  = 7'(alm_hi) * 7'd10 + 7'(alm_lo);

    a_r2_digits_valid: assert property (@(posedge clk) disable iff (rst)
        (cnt_lo <= 4'd9) && (live_bin < 7'(MODULUS)) && (alm_lo <= 4'd9) && (alm_bin < 7'(MODULUS)));

    a_r3_idle_holds: assert property (@(posedge clk) disable iff (rst)
        (!clr && !key && !en) |=> $stable({cnt_hi, cnt_lo}));

    a_r4_carry_near_zero: assert property (@(posedge clk) disable iff (rst)
        carry |-> (live_bin <= 7'd1));

    a_r5_key_moves_time: assert property (@(posedge clk) disable iff (rst)
        (key && !sel_alarm && !clr && !tick) |=> !$stable({cnt_hi, cnt_lo}));

    a_r6_alarm_keeps_time: assert property (@(posedge clk) disable iff (rst)
        (key && sel_alarm && !clr && !(tick && en)) |=> $stable({cnt_hi, cnt_lo}));

    a_r6_alarm_only_by_key: assert property (@(posedge clk) disable iff (rst)
        !(key && sel_alarm) |=> $stable({alm_hi, alm_lo}));

    a_r7_clear_zeroes: assert property (@(posedge clk) disable iff (rst)
        clr |=> (live_bin == 7'd0) && !carry);

    a_r8_beeps_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({beep_lo, beep_hi}));
endmodule

bind bcd_mod_counter bcd_mod_counter_chk #(.MODULUS(MODULUS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .en        (en),
    .clr       (clr),
    .key       (key),
    .sel_alarm (sel_alarm),
    .cnt_hi    (cnt_hi),
    .cnt_lo    (cnt_lo),
    .alm_hi    (alm_hi),
    .alm_lo    (alm_lo),
    .carry     (carry),
    .beep_lo   (beep_lo),
    .beep_hi   (beep_hi)
);

// File: tb/bcd_mod_counter_test.sv
module bcd_mod_counter_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0, en = 1'b0, clr = 1'b0, key = 1'b0, sel_alarm = 1'b0;
    logic [3:0] cnt_hi, cnt_lo, alm_hi, alm_lo;
    logic       carry, beep_lo, beep_hi;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    int    mcnt = 0, malm = 0;
    bit    mcar = 0;
    string ltag = "R1";

    always #5 clk = ~clk;

    bcd_mod_counter uut (
        .clk(clk), .rst(rst), .tick(tick), .en(en), .clr(clr), .key(key),
        .sel_alarm(sel_alarm), .cnt_hi(cnt_hi), .cnt_lo(cnt_lo),
        .alm_hi(alm_hi), .alm_lo(alm_lo), .carry(carry),
        .beep_lo(beep_lo), .beep_hi(beep_hi)
    );

    task automatic cmp(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Compare every output with the model (state after the last edge).
    task automatic check_all();
        bit elo, ehi;
        elo = (mcnt >= 50) && (mcnt < 60) && (mcnt % 2 == 0);   // R8
        ehi = (mcnt == 0);                                        // R9
        cmp(ltag, "live count", int'(cnt_hi) * 10 + int'(cnt_lo), mcnt);
        cmp(ltag, "units digit", int'(cnt_lo), mcnt % 10);
        cmp("R6", "alarm value", int'(alm_hi) * 10 + int'(alm_lo), malm);
        cmp("R4", "carry", int'(carry), int'(mcar));
        cmp("R8", "beep_lo", int'(beep_lo), int'(elo));
        cmp("R9", "beep_hi", int'(beep_hi), int'(ehi));
    endtask

    // One cycle: check at the falling edge, then apply the next inputs.
    task automatic step(bit t, bit e, bit k, bit s, bit c);
        int n;
        @(negedge clk);
        check_all();
        tick = t; en = e; key = k; sel_alarm = s; clr = c;
        n = int'(t && e) + int'(k && !s);
        if (c) begin
            mcnt = 0; mcar = 0; ltag = "R7";
        end else begin
            mcar = (mcnt + n >= 60);
            mcnt = (mcnt + n) % 60;
            if (k && !s)       ltag = "R5";
            else if (t && !e)  ltag = "R3";
            else               ltag = "R2";
        end
        if (k && s) malm = (malm + 1) % 60;
    endtask

    initial begin
        logic [15:0] lfsr;
        // R1: reset state, with busy inputs held during reset
        tick = 1'b1; en = 1'b1; key = 1'b1; sel_alarm = 1'b1;
        repeat (3) @(negedge clk);
        ltag = "R1";
        check_all();
        rst = 1'b0;
        tick = 1'b0; key = 1'b0; en = 1'b0; sel_alarm = 1'b0;

        // R2, R4, R8, R9: several full laps of plain counting
        for (int i = 0; i < 130; i++) step(1, 1, 0, 0, 0);
        // R3: ticks with counting disabled
        for (int i = 0; i < 12; i++) step(1, 0, 0, 0, 0);
        // R6: alarm lap plus overshoot, live count still ticking
        for (int i = 0; i < 65; i++) step(i % 2, 1, 1, 1, 0);
        // R5: time key alone with counting disabled, through a wrap
        for (int i = 0; i < 70; i++) step(0, 0, 1, 0, 0);
        // R5: key plus tick double steps through several wraps
        for (int i = 0; i < 100; i++) step(1, 1, 1, 0, 0);
        // R7: clear while ticking and keying; alarm must survive
        step(1, 1, 1, 0, 1);
        step(0, 0, 0, 0, 0);
        for (int i = 0; i < 59; i++) step(1, 1, 0, 0, 0);
        step(1, 1, 0, 0, 1);   // clear on the would-be wrap
        step(0, 0, 0, 0, 0);

        // Mixed pseudo-random traffic
        lfsr = 16'hACE1;
        for (int i = 0; i < 4000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[0] | lfsr[1], lfsr[2] | lfsr[3], lfsr[4] & lfsr[5],
                 lfsr[6] & lfsr[9], lfsr[11:7] == 5'd0);
        end
        @(negedge clk);
        check_all();

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule